// File: doc/BRIEF.md
# Mask-Driven Permute Control Generator

This block builds a permute control vector from a 128-bit input vector. The input is treated as a row of elements of 1, 2, 4 or 8 bytes. Each element offers one mask bit, and the output is a list of 16 byte indices that a separate byte-permute unit can use to gather from, or scatter into, a pair of 16-byte sources. Selected elements receive consecutive indices. The running index for each element is a prefix count of the selected elements before it, multiplied by the element size.

A 5-bit immediate chooses one of four modes. The modes combine big- or little-endian element numbering with either expansion (scatter selected positions into place) or compression (pack selected elements toward one end). Each mode has its own fill for the bytes that no selected element writes. Immediate values above 3 are illegal. For those the block raises a flag and gives a zero vector. The result is registered and appears one clock after an accepted input.

Top module: `pcv_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `out_valid`, `out_illegal` and `out_vec` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `out_vec` keeps its value in every cycle that follows a cycle without `in_valid`.
- R3: Byte position p (0 to 15) is `in_vec[127-8p -: 8]`, and the same layout holds for `out_vec`. `size_sel` 0, 1, 2 and 3 selects elements of 1, 2, 4 and 8 bytes. Element e starts at byte e*S, where S is the element size. Its mask bit is bit 7 of that first byte. No other input bit affects the result.
- R4: Immediate 0 (big-endian expand). Unwritten byte p holds 16+p. Elements are numbered upward from byte 0, and c counts the selected elements below element e. For a selected element e, byte e*S+k holds c*S+k.
- R5: Immediate 1 (big-endian compress). Unwritten bytes are 0. For a selected element e, with c counting the selected elements below it, byte c*S+k holds e*S+k.
- R6: Immediate 2 (little-endian expand). Unwritten byte p holds 31-p. For a selected element e, with c counting the selected elements above it, byte e*S+m holds c*S+(S-1-m).
- R7: Immediate 3 (little-endian compress). Unwritten bytes are 0. For a selected element e, with c counting the selected elements above it, byte 16-(c+1)*S+m holds 16-(e+1)*S+(S-1-m).
- R8: An accepted input with an immediate of 4 to 31 produces `out_illegal` high and an all-zero `out_vec` in the cycle it appears. `out_illegal` is low on every other output.
- R9: With no mask bit set, the result is the mode's fill pattern. With every mask bit set, the big-endian modes give bytes 0,1,...,15, and the little-endian modes give 15,14,...,0, at every element size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input accepted this cycle |
| in_vec | input | 128 | Source vector carrying the mask bits |
| size_sel | input | 2 | Element size select: 1, 2, 4 or 8 bytes |
| imm | input | 5 | Mode immediate; only 0 to 3 are legal |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_vec | output | 128 | Permute control vector, 16 byte indices |
| out_illegal | output | 1 | Result came from an illegal immediate |

## Verification
The bench aims at the boundaries of the prefix count. With every mask set, a design that counts one element too few or too many writes an index past the end of the result, or leaves a gap. With no mask set, a wrong fill pattern shows, for example a little-endian mode that keeps the big-endian ramp. Bytes that carry only low-order bits with no mask bit catch a design that reads the wrong bit or the wrong byte of each element. Random vectors at all four sizes expose swapped element or byte order within the little-endian modes and wrong offsets in compression. Illegal immediates sent back to back with legal ones catch a flag that sticks, a result that leaks through, or an output that fails to hold between inputs.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

  typedef enum logic [1:0] {
    MODE_BE_EXPAND   = 2'd0,
    MODE_BE_COMPRESS = 2'd1,
    MODE_LE_EXPAND   = 2'd2,
    MODE_LE_COMPRESS = 2'd3
  } pcv_mode_e;

  localparam int NUM_SIZES = 4;

  function automatic logic imm_is_legal(input logic [4:0] imm);
    return imm[4:2] == 3'b000;
  endfunction

endpackage

// File: rtl/pcv_prefix_count.sv
module pcv_prefix_count #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  flag,
  output logic [CW-1:0] cnt_below [N],
  output logic [CW-1:0] cnt_above [N]
);

  logic [CW-1:0] acc_lo;
  logic [CW-1:0] acc_hi;

  // exclusive prefix count from element 0 upward
  always_comb begin
    acc_lo = '0;
    for (int e = 0; e < N; e++) begin
      cnt_below[e] = acc_lo;
      acc_lo = acc_lo + CW'(flag[e]);
    end
  end

  // exclusive suffix count from the last element downward
  always_comb begin
    acc_hi = '0;
    for (int e = N - 1; e >= 0; e--) begin
      cnt_above[e] = acc_hi;
      acc_hi = acc_hi + CW'(flag[e]);
    end
  end

endmodule

// File: rtl/pcv_size_map.sv
module pcv_size_map
  import pcv_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int ESZ    = 1,
  localparam int NE    = NBYTES / ESZ,
  localparam int CW    = $clog2(NE + 1),
  localparam int IDXW  = $clog2(NBYTES),
  localparam int W     = 8 * NBYTES
) (
  input  logic [NBYTES-1:0] byte_msb,
  input  pcv_mode_e         mode,
  output logic [W-1:0]      res
);

  logic [NE-1:0] flag;
  logic [CW-1:0] cnt_below [NE];
  logic [CW-1:0] cnt_above [NE];
  logic [7:0]    r [NBYTES];
  logic          unused_msb;

  assign unused_msb = ^byte_msb;

  // the mask bit of an element sits in its first (most significant) byte
  for (genvar e = 0; e < NE; e++) begin : g_flag
    assign flag[e] = byte_msb[e*ESZ];
  end

  pcv_prefix_count #(.N(NE)) u_count (
    .flag      (flag),
    .cnt_below (cnt_below),
    .cnt_above (cnt_above)
  );

  always_comb begin
    for (int p = 0; p < NBYTES; p++) begin
      case (mode)
        MODE_BE_EXPAND: r[p] = 8'(NBYTES + p);
        MODE_LE_EXPAND: r[p] = 8'(2*NBYTES - 1 - p);
        default:        r[p] = 8'd0;
      endcase
    end
    for (int e = 0; e < NE; e++) begin
      if (flag[e]) begin
        for (int m = 0; m < ESZ; m++) begin
          case (mode)
            MODE_BE_EXPAND:
              r[IDXW'(e*ESZ + m)] = 8'(int'(cnt_below[e])*ESZ + m);
            MODE_BE_COMPRESS:
              r[IDXW'(int'(cnt_below[e])*ESZ + m)] = 8'(e*ESZ + m);
            MODE_LE_EXPAND:
              r[IDXW'(e*ESZ + m)] = 8'(int'(cnt_above[e])*ESZ + ESZ - 1 - m);
            default:
              r[IDXW'(NBYTES - (int'(cnt_above[e]) + 1)*ESZ + m)] =
                8'(NBYTES - (e + 1)*ESZ + ESZ - 1 - m);
          endcase
        end
      end
    end
  end

  for (genvar p = 0; p < NBYTES; p++) begin : g_pack
    assign res[W-1-8*p -: 8] = r[p];
  end

endmodule

// File: rtl/pcv_gen.sv
module pcv_gen
  import pcv_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int W     = 8 * NBYTES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_vec,
  input  logic [1:0]   size_sel,
  input  logic [4:0]   imm,
  output logic         out_valid,
  output logic [W-1:0] out_vec,
  output logic         out_illegal
);

  logic [NBYTES-1:0] byte_msb;
  logic [W-1:0]      map_res [NUM_SIZES];
  logic              legal;
  logic              unused_payload;
  pcv_mode_e         mode;

  assign unused_payload = ^in_vec;
  assign legal          = imm_is_legal(imm);
  assign mode           = pcv_mode_e'(imm[1:0]);

  for (genvar p = 0; p < NBYTES; p++) begin : g_msb
    assign byte_msb[p] = in_vec[W-1-8*p];
  end

  // one mapper per element size: 1, 2, 4, 8 bytes
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    pcv_size_map #(.NBYTES(NBYTES), .ESZ(1 << s)) u_map (
      .byte_msb (byte_msb),
      .mode     (mode),
      .res      (map_res[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !legal;
      if (in_valid) out_vec <= legal ? map_res[size_sel] : '0;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));

  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_vec == '0) && out_valid);

  a_r8_flag_raised: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm[4:2] != 3'b000) |=> out_illegal);

endmodule

// File: tb/tb_pcv_gen.sv
module tb_pcv_gen;

  localparam int NB = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_vec = '0;
  logic [1:0]   size_sel = '0;
  logic [4:0]   imm = '0;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         out_illegal;

  int tests = 0;
  int fails = 0;

  logic         exp_valid = 1'b0;
  logic         exp_ill   = 1'b0;
  logic [127:0] exp_vec   = '0;
  string        exp_tag   = "R1";

  always #5 clk = ~clk;

  pcv_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .size_sel(size_sel), .imm(imm), .out_valid(out_valid),
    .out_vec(out_vec), .out_illegal(out_illegal)
  );

  // scan-based behavioural model with a running index
  function automatic logic [127:0] ref_pcv(input logic [127:0] v, input int sel, input int md);
    int b [NB];
    int t [NB];
    int s = 1 << sel;
    int j = 0;
    logic [127:0] o;
    for (int p = 0; p < NB; p++) begin
      b[p] = int'(v[127-8*p -: 8]);
      t[p] = (md == 0) ? 16 + p : (md == 2) ? 31 - p : 0;
    end
    for (int i = 0; i < NB; i += s) begin
      int src = (md >= 2) ? NB - i - s : i;
      if ((b[src] & 8'h80) != 0) begin
        for (int k = 0; k < s; k++) begin
          case (md)
            0: t[i + k] = j + k;
            1: t[j + k] = i + k;
            2: t[src + s - 1 - k] = j + k;
            default: t[NB - j - s + s - 1 - k] = i + k;
          endcase
        end
        j += s;
      end
    end
    for (int p = 0; p < NB; p++) o[127-8*p -: 8] = 8'(t[p]);
    return o;
  endfunction

  function automatic string tag_for(input logic [127:0] v, input int sel, input int md);
    int s = 1 << sel;
    int hits = 0;
    for (int e = 0; e < NB; e += s) hits += int'(v[127-8*e]);
    if (md > 3) return "R8";
    if (v == '0 || hits == NB / s) return "R9";
    if (hits == 0) return "R3";
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_outputs();
    tests++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end
    tests++;
    if (out_illegal !== exp_ill) begin
      fails++;
      $display("FAIL R8 out_illegal actual=%0b expected=%0b", out_illegal, exp_ill);
    end
    tests++;
    if (out_vec !== exp_vec) begin
      fails++;
      $display("FAIL %s out_vec actual=%h expected=%h", exp_valid ? exp_tag : "R2",
               out_vec, exp_vec);
    end
  endtask

  // one clock: check the previous cycle's prediction, then drive the next input
  task automatic step(input logic v, input logic [127:0] vec, input int sel, input int im);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_vec   = vec;
    size_sel = 2'(sel);
    imm      = 5'(im);
    exp_valid = v;
    exp_ill   = v && (im > 3);
    if (v) begin
      exp_vec = (im > 3) ? '0 : ref_pcv(vec, sel, im);
      exp_tag = tag_for(vec, sel, im);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    exp_tag = "R1";
    tests++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_vec !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b/%0b/%h expected=0/0/0", out_valid, out_illegal, out_vec);
    end
    rst = 1'b0;
    step(1'b0, '0, 0, 0);
    for (int sel = 0; sel < 4; sel++) begin
      for (int md = 0; md < 4; md++) begin
        step(1'b1, '0, sel, md);
        step(1'b1, {128{1'b1}}, sel, md);
        step(1'b1, {16{8'h7F}}, sel, md);
        step(1'b0, rnd128(), sel, md);
        step(1'b1, {8{16'h8000}}, sel, md);
        step(1'b1, {4{32'h0080_8000}}, sel, md);
        for (int n = 0; n < 8; n++) step(1'b1, rnd128(), sel, md);
        step(1'b0, '0, 0, 0);
      end
    end
    // R8: illegal immediates between legal ones
    for (int n = 0; n < 12; n++) begin
      step(1'b1, rnd128(), n % 4, 4 + (n * 7) % 28);
      step(1'b1, rnd128(), n % 4, n % 4);
      step(1'b0, rnd128(), 0, 31);
    end
    // mixed back-to-back stream
    for (int n = 0; n < 300; n++) begin
      int im = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 4);
      step(($urandom % 4) != 0, rnd128(), int'($urandom % 4), im);
    end
    step(1'b0, '0, 0, 0);
    step(1'b0, '0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule